// File: doc/BRIEF.md
# Per-Channel ADC Sample-Time Controller

This block sets the length of the sampling window for each input channel of an ADC. A register bank holds a 3-bit duration code for each of 19 channels, spread over two 32-bit words. A global extend flag lengthens only the shortest setting. When a sequencer pulses `start` with a channel number, the block captures that channel's code and turns it into a duration in half ADC clock periods. It then holds `sample_win` high for that many half-period ticks and raises `done` for one clock cycle.

The block runs at twice the ADC clock rate. `tick_en` marks each cycle that counts as one half ADC period, so a duration such as 2.5 ADC cycles becomes 5 ticks. Software reads and writes the two code words over a simple single-cycle bus. Writes are refused while the regular or the injected conversion status input is high, so the codes cannot change during a conversion.

Top module: `adc_smp_timer`

## Requirements
- R1: After reset, both code words read as zero (every channel uses code 000, extend flag clear), and `sample_win`, `done` and `busy` are low.
- R2: The window length in ticks is twice the duration of the code: 000=5, 001=13, 010=25, 011=49, 100=95, 101=185, 110=495, 111=1281.
- R3: When bit 31 of the word at offset 0x14 (extend flag) is set, code 000 lasts 7 ticks on every channel. All other codes keep their lengths.
- R4: The word at 0x14 holds channel n (0 to 9) in bits 3n+2:3n. The word at 0x18 holds channel n (10 to 18) in bits 3(n-10)+2:3(n-10), so channel 15 spans bits 17:15.
- R5: Bit 30 of 0x14 and bits 31:27 of 0x18 are discarded on write and read as zero. Any other offset reads as zero, and writes to it change nothing.
- R6: A write to either word, the extend flag included, is ignored while `conv_reg_act` or `conv_inj_act` is high.
- R7: After an accepted start, `sample_win` is high from the next cycle until exactly N cycles with `tick_en` high have passed, where N is the length in ticks. `done` is high for the one cycle that follows.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle. A start that arrives while `busy` is high is ignored.
- R9: The channel and its length are captured at start. Changes to `chan` or to the code words during a window do not change that window.
- R10: Channel numbers 19 to 31 use code 000, and the extend flag still applies to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the ADC clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | High for each cycle that counts as one half ADC period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| conv_reg_act | input | 1 | A regular conversion is active |
| conv_inj_act | input | 1 | An injected conversion is active |
| start | input | 1 | Request a sampling window |
| chan | input | 5 | Channel to sample |
| sample_win | output | 1 | Sampling window active |
| done | output | 1 | One-cycle pulse after the window closes |
| busy | output | 1 | Window or done pulse in progress |

## Verification
The assertions check on every cycle the properties that need no knowledge of the stored codes. `done` must follow a window and cannot repeat in the next cycle. `busy` stays up until `done`, only a start can raise it, and the window closes only on a tick. Read data does not change during a locked cycle. The length of each window in ticks, the field layout of both words, the effect of the extend flag, and the capture of the channel at start all depend on the register contents. The bench's scoreboard scenarios check those, including windows with gaps in `tick_en` and a start during an active window.

// File: rtl/adc_smp_pkg.sv
package adc_smp_pkg;

    localparam int CODE_W = 3;
    localparam int TICK_W = 11;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_OPEN = 2'd1,
        WIN_DONE = 2'd2
    } win_st_e;

    typedef struct packed {
        win_st_e             st;
        logic [TICK_W-1:0]   cnt;
    } win_reg_t;

    // Duration code to window length in half ADC periods.
    function automatic logic [TICK_W-1:0] code_ticks(input logic [CODE_W-1:0] code,
                                                     input logic              extend);
        logic [TICK_W-1:0] t;
        case (code)
            3'd0:    t = extend ? TICK_W'(7) : TICK_W'(5);
            3'd1:    t = TICK_W'(13);
            3'd2:    t = TICK_W'(25);
            3'd3:    t = TICK_W'(49);
            3'd4:    t = TICK_W'(95);
            3'd5:    t = TICK_W'(185);
            3'd6:    t = TICK_W'(495);
            default: t = TICK_W'(1281);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/adc_smp_regs.sv
module adc_smp_regs
    import adc_smp_pkg::*;
#(
    parameter int                NUM_CH = 19,
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFS_LO = 8'h14,
    parameter logic [ADDR_W-1:0] OFS_HI = 8'h18,
    localparam int               ALL_BITS = NUM_CH * CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                lock_reg,
    input  logic                lock_inj,
    output logic [DATA_W-1:0]   rdata,
    output logic [ALL_BITS-1:0] codes,
    output logic                extend
);

    localparam int LO_CH   = 10;
    localparam int LO_BITS = LO_CH * CODE_W;
    localparam int HI_BITS = ALL_BITS - LO_BITS;
    localparam int EXT_BIT = DATA_W - 1;

    typedef struct packed {
        logic                extend;
        logic [ALL_BITS-1:0] codes;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  wr_ok;

    always_comb begin
        bank_d = bank_q;
        wr_ok  = wr_en && !lock_reg && !lock_inj;
        if (wr_ok) begin
            if (addr == OFS_LO) begin
                bank_d.codes[LO_BITS-1:0] = wdata[LO_BITS-1:0];
                bank_d.extend             = wdata[EXT_BIT];
            end else if (addr == OFS_HI) begin
                bank_d.codes[ALL_BITS-1:LO_BITS] = wdata[HI_BITS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_LO) begin
            rdata[LO_BITS-1:0] = bank_q.codes[LO_BITS-1:0];
            rdata[EXT_BIT]     = bank_q.extend;
        end else if (addr == OFS_HI) begin
            rdata[HI_BITS-1:0] = bank_q.codes[ALL_BITS-1:LO_BITS];
        end
    end

    assign codes  = bank_q.codes;
    assign extend = bank_q.extend;

endmodule

// File: rtl/adc_smp_sel.sv
module adc_smp_sel
    import adc_smp_pkg::*;
#(
    parameter int  NUM_CH = 19,
    parameter int  CH_W   = 5,
    localparam int ALL_BITS = NUM_CH * CODE_W
) (
    input  logic [ALL_BITS-1:0] codes,
    input  logic                extend,
    input  logic [CH_W-1:0]     chan,
    output logic [TICK_W-1:0]   ticks
);

    logic [CODE_W-1:0] code;

    // Unconnected channel numbers fall through to code 000.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan == CH_W'(i)) code = codes[i*CODE_W +: CODE_W];
        end
        ticks = code_ticks(code, extend);
    end

endmodule

// File: rtl/adc_smp_window.sv
module adc_smp_window
    import adc_smp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              start,
    input  logic [TICK_W-1:0] ticks_in,
    output logic              win,
    output logic              done,
    output logic              busy
);

    win_reg_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            WIN_IDLE: begin
                if (start) begin
                    w_d.st  = WIN_OPEN;
                    w_d.cnt = ticks_in;
                end
            end
            WIN_OPEN: begin
                if (tick_en) begin
                    if (w_q.cnt <= TICK_W'(1)) w_d.st = WIN_DONE;
                    else                       w_d.cnt = w_q.cnt - TICK_W'(1);
                end
            end
            default: begin
                w_d.st  = WIN_IDLE;
                w_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WIN_IDLE, cnt: '0};
        else        w_q <= w_d;
    end

    assign win  = (w_q.st == WIN_OPEN);
    assign done = (w_q.st == WIN_DONE);
    assign busy = (w_q.st != WIN_IDLE);

endmodule

// File: rtl/adc_smp_timer.sv
module adc_smp_timer
    import adc_smp_pkg::*;
#(
    parameter int                NUM_CH = 19,
    parameter int                CH_W   = 5,
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFS_LO = 8'h14,
    parameter logic [ADDR_W-1:0] OFS_HI = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_reg_act,
    input  logic              conv_inj_act,
    input  logic              start,
    input  logic [CH_W-1:0]   chan,
    output logic              sample_win,
    output logic              done,
    output logic              busy
);

    localparam int ALL_BITS = NUM_CH * CODE_W;

    logic [ALL_BITS-1:0] codes;
    logic                extend;
    logic [TICK_W-1:0]   ticks;

    adc_smp_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_LO (OFS_LO),
        .OFS_HI (OFS_HI)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .lock_reg (conv_reg_act),
        .lock_inj (conv_inj_act),
        .rdata    (bus_rdata),
        .codes    (codes),
        .extend   (extend)
    );

    adc_smp_sel #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) sel_i (
        .codes  (codes),
        .extend (extend),
        .chan   (chan),
        .ticks  (ticks)
    );

    adc_smp_window win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .start    (start),
        .ticks_in (ticks),
        .win      (sample_win),
        .done     (done),
        .busy     (busy)
    );

endmodule

// File: rtl/adc_smp_checker.sv
module adc_smp_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              start,
    input logic              sample_win,
    input logic              done,
    input logic              busy,
    input logic              conv_reg_act,
    input logic              conv_inj_act,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    assert_done_after_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sample_win));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_close_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_win) |-> $past(tick_en));

    assert_win_excl_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_win && done));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_win_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_win |-> busy);

    assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_reg_act || conv_inj_act) |=> (!$stable(bus_addr) || $stable(bus_rdata)));

endmodule

bind adc_smp_timer adc_smp_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .start        (start),
    .sample_win   (sample_win),
    .done         (done),
    .busy         (busy),
    .conv_reg_act (conv_reg_act),
    .conv_inj_act (conv_inj_act),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata)
);

// File: tb/adc_smp_timer_tb_top.sv
`timescale 1ns/1ps
module adc_smp_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_reg_act = 1'b0;
    logic        conv_inj_act = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  chan = '0;
    logic        sample_win, done, busy;

    int errors = 0;
    int checks = 0;
    int tick_mode = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int done_seen = 0;
    int exp_q[$];
    string req_q[$];

    always #10 clk = ~clk;

    adc_smp_timer dut_i (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .conv_reg_act (conv_reg_act),
        .conv_inj_act (conv_inj_act), .start (start), .chan (chan),
        .sample_win (sample_win), .done (done), .busy (busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int code, input bit ext);
        case (code)
            0: return ext ? 7 : 5;
            1: return 13;
            2: return 25;
            3: return 49;
            4: return 95;
            5: return 185;
            6: return 495;
            default: return 1281;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic launch(input int ch, input int exp, input string req);
        @(posedge clk); #1;
        chan = 5'(ch); start = 1'b1;
        exp_q.push_back(exp); req_q.push_back(req);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_win(input int ch, input int exp, input string req);
        launch(ch, exp, req);
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        wait_idle();
    endtask

    // Tick source: steady or with gaps.
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            tick_en = (tick_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        end
    end

    // Scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sample_win && tick_en) tick_cnt++;
                if (done) begin
                    done_seen++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected done", tick_cnt, 0);
                    end else begin
                        int e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        chk(tick_cnt == e, r, tick_cnt, e);
                    end
                    tick_cnt = 0;
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          n;
        int          cycles;
        repeat (3) @(posedge clk);
        // R1 reset state
        rd_chk(8'h14, 32'h0, "R1 lo word reset");
        rd_chk(8'h18, 32'h0, "R1 hi word reset");
        chk({sample_win, done, busy} == 3'b000, "R1 outputs reset", {sample_win, done, busy}, 0);
        #3 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R4 / R5 layout and reserved bits
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'hBFFF_FFFF, "R5 bit30 reads zero");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk(8'h18, 32'h07FF_FFFF, "R5 hi reserved read zero");
        wr(8'h1C, 32'h0);
        rd_chk(8'h1C, 32'h0, "R5 other offset reads zero");
        rd_chk(8'h14, 32'hBFFF_FFFF, "R5 other offset write no effect");

        // R2 full table on channels 0..7
        v = '0;
        for (int k = 0; k < 8; k++) v |= 32'(k) << (3 * k);
        wr(8'h14, v);
        rd_chk(8'h14, v, "R4 lo word readback");
        for (int k = 0; k < 8; k++) run_win(k, len_of(k, 0), "R2 code length");

        // R4 high word: channel n code 7-((n-10)%8)
        v = '0;
        for (int m = 10; m < 19; m++) v |= 32'(7 - ((m - 10) % 8)) << (3 * (m - 10));
        wr(8'h18, v);
        run_win(15, 25, "R4 ch15 across bits 17:15");
        run_win(18, 1281, "R4 ch18 top field");

        // R3 extend flag
        wr(8'h14, 32'h8000_0008);
        rd_chk(8'h14, 32'h8000_0008, "R3 flag readback");
        run_win(0, 7, "R3 code0 extended");
        run_win(1, 13, "R3 code1 unchanged");
        run_win(17, 7, "R3 hi word code0 extended");
        run_win(25, 7, "R10 unconnected with flag");
        wr(8'h14, 32'h0000_0008);
        run_win(25, 5, "R10 unconnected code0");
        run_win(0, 5, "R3 flag cleared");

        // R6 write lock
        conv_reg_act = 1'b1;
        wr(8'h14, 32'hFFFF_FFFF);
        conv_reg_act = 1'b0;
        rd_chk(8'h14, 32'h0000_0008, "R6 regular lock lo word");
        conv_inj_act = 1'b1;
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h8000_0000);
        conv_inj_act = 1'b0;
        rd_chk(8'h18, v, "R6 injected lock hi word");
        rd_chk(8'h14, 32'h0000_0008, "R6 injected lock flag");
        run_win(0, 5, "R6 flag not set while locked");

        // R7 window with tick gaps
        tick_mode = 1;
        launch(1, 13, "R7 ticks with gaps");
        cycles = 0;
        @(negedge clk);
        while (sample_win) begin cycles++; @(negedge clk); end
        chk(done == 1'b1, "R7 done after window", done, 1);
        chk(cycles > 13, "R7 window stretched by gaps", cycles, 14);
        wait_idle();
        tick_mode = 0;

        // R8 start while busy ignored
        n = done_seen;
        launch(1, 13, "R8 first window kept");
        repeat (3) @(posedge clk);
        #1; chan = 5'd15; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(done_seen == n + 1, "R8 one done only", done_seen - n, 1);
        chk(busy == 1'b0, "R8 idle after done", busy, 0);

        // R9 capture at start
        launch(1, 13, "R9 captured length");
        #1; chan = 5'd18;
        wr(8'h14, 32'h0000_0010);
        wait_idle();
        run_win(1, 25, "R9 new code after window");

        chk(exp_q.size() == 0, "R7 all windows completed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule